// File: doc/BRIEF.md
# Serial ADC Frame Sequencer

This block sits on the host side of a small successive-approximation converter with a three-wire serial port. It owns chip select and the serial clock. It runs conversion frames, shifts the result bits in from the converter's data line and hands each finished sample to the fabric as a one-cycle strobe with data. The serial clock is produced by dividing the system clock by a parameter. Each clock phase lasts `CLK_DIV` system cycles, so the divider must be chosen to keep the serial clock at or below 25 MHz.

Besides plain reads, the block can send the converter to sleep. It does this by cutting a frame short inside the window the converter treats as a power-down command. On a later request it wakes the converter with a dummy frame, waits out the power-up delay and throws away the first, unreliable result. A start that arrives while the converter sleeps or is waking is remembered and served once the converter is usable again.

An 8-bit build can use a shortened 12-clock frame for higher throughput.

Top module: `adc_rd_ctrl`

## Requirements
- R1: A read frame drops chip select, then produces exactly 16 serial-clock falling edges, or 12 when `SHORT_FRAME` is set and `DATA_W` is 8 or less. Chip select rises on the same system edge as the serial clock's rising edge after the last fall. The serial clock rests high whenever chip select is high.
- R2: Serial position 0 is the bit present after chip select falls, and position k is the bit present after the k-th falling edge. The result is positions 4 through 3+`DATA_W`, most significant bit first. Each bit is sampled when the serial clock rises after its falling edge. The result appears on `smp_data_o` with a one-cycle `smp_valid_o` pulse in the cycle chip select rises.
- R3: Within a frame every serial-clock low phase lasts `CLK_DIV` system cycles. The first falling edge comes `CLK_DIV` cycles after chip select falls.
- R4: Between any two frames chip select stays high for at least `QUIET_CYC` system cycles.
- R5: `ready_o` is high only when the converter is awake, no frame, quiet period or wake delay is running, and no start is held. It is high after reset.
- R6: A start pulse during a read frame or the quiet period after it is dropped.
- R7: A power-down request in the ready state runs a frame in which chip select rises at the serial-clock rising edge after falling edge `PD_EDGE` (3 to 9). No sample is issued, and the block then stays asleep with `ready_o` low.
- R8: A wake request while asleep runs a dummy frame of 11 falling edges with no sample. The next chip-select fall comes at least `WAKE_CYC` cycles after the dummy frame's chip-select fall.
- R9: The frame after the dummy frame is a full read whose result is discarded; no `smp_valid_o` is issued for it.
- R10: A start pulse that arrives while asleep, during a power-down frame, or during the wake sequence is held. It launches exactly one read after the discarded frame and its quiet period. No frame is started for it while the converter sleeps.
- R11: With `SHORT_FRAME` set and 8-bit data, the read frame ends after 12 falling edges and returns the 8 data bits from positions 4 to 11.
- R12: When a start pulse and a power-down request arrive together in the ready state, the read is run and the power-down request is dropped.
- R13: A wake request while awake, and a power-down request during a read frame, start no frame and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request for a conversion |
| pd_req_i | input | 1 | One-cycle request to put the converter to sleep |
| wake_req_i | input | 1 | One-cycle request to wake the converter |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| smp_valid_o | output | 1 | One-cycle strobe marking a new sample |
| smp_data_o | output | DATA_W | Most recent sample |
| ready_o | output | 1 | Block can accept a start or power-down request |

## Verification
The bench drives a behavioural converter that shifts a known word onto the data line. It goes after the edge counts of each frame kind. A sequencer that ends the power-down frame at the wrong edge leaves the converter awake, or aborts a normal read. One that shortens the dummy frame or starts the next frame early breaks the wake timing. It also targets the discarded post-wake frame and the held start. A design that issues a sample for the discarded frame, or that loses or duplicates a start made during sleep, shows up as a wrong sample count. Starts during busy frames, simultaneous start and power-down requests, and the 12-clock frame are each checked, because a wrong priority or a wrong capture window changes the frame count or the returned bits.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_QUIET,
    ST_SLEEP,
    ST_WAKE
  } seq_st_t;

  typedef enum logic [1:0] {
    FK_READ,
    FK_PWRDN,
    FK_DUMMY,
    FK_DISCARD
  } frame_kind_t;

  // serial positions before the first result bit
  localparam int LEAD_BITS   = 4;
  localparam int FULL_FALLS  = 16;
  localparam int SHORT_FALLS = 12;
  // dummy frame must exceed ten falling edges
  localparam int WAKE_FALLS  = 11;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int CLK_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_o,
  output logic fall_now_o,
  output logic rise_now_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] cnt;
  logic          tgl;

  assign tgl        = run && (cnt == DW'(CLK_DIV - 1));
  assign fall_now_o = tgl && sclk_o;
  assign rise_now_o = tgl && !sclk_o;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      sclk_o <= 1'b1;
    end else if (tgl) begin
      cnt    <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_i,
  input  logic              sdo_i,
  input  logic              emit_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= emit_i;
      if (shift_i) shreg  <= {shreg[DATA_W-2:0], sdo_i};
      if (emit_i)  data_o <= shreg;
    end
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SHORT_FRAME = 0,
  parameter int QUIET_CYC   = 6,
  parameter int WAKE_CYC    = 100,
  parameter int PD_EDGE     = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic pd_req_i,
  input  logic wake_req_i,
  input  logic fall_now_i,
  input  logic rise_now_i,
  output logic run_o,
  output logic cs_n_o,
  output logic shift_o,
  output logic emit_o,
  output logic ready_o
);
  localparam int READ_FALLS = (SHORT_FRAME != 0 && DATA_W <= 8) ? SHORT_FALLS : FULL_FALLS;
  localparam int FCW = $clog2(FULL_FALLS + 1);
  localparam int QW  = $clog2(QUIET_CYC + 1);
  localparam int WW  = $clog2(WAKE_CYC + 1);

  seq_st_t     state;
  frame_kind_t kind, go_kind;
  logic [FCW-1:0] fcnt, end_falls;
  logic [QW-1:0]  qcnt;
  logic [WW-1:0]  wcnt;
  logic pend, go, end_hit, in_win, hold_ok;

  always_comb begin
    case (kind)
      FK_PWRDN: end_falls = FCW'(PD_EDGE);
      FK_DUMMY: end_falls = FCW'(WAKE_FALLS);
      default:  end_falls = FCW'(READ_FALLS);
    endcase
  end

  assign end_hit = (state == ST_FRAME) && rise_now_i && (fcnt == end_falls);
  assign in_win  = (fcnt >= FCW'(LEAD_BITS)) && (fcnt < FCW'(LEAD_BITS + DATA_W));
  assign shift_o = (state == ST_FRAME) && (kind == FK_READ) && rise_now_i && in_win;
  assign emit_o  = end_hit && (kind == FK_READ);
  assign ready_o = (state == ST_IDLE) && !pend;
  assign hold_ok = (state == ST_SLEEP) || (state == ST_WAKE) ||
                   (((state == ST_FRAME) || (state == ST_QUIET)) && (kind != FK_READ));

  always_comb begin
    go      = 1'b0;
    go_kind = FK_READ;
    case (state)
      ST_IDLE: begin
        if (start_i || pend) begin
          go = 1'b1;
        end else if (pd_req_i) begin
          go      = 1'b1;
          go_kind = FK_PWRDN;
        end
      end
      ST_SLEEP: begin
        if (wake_req_i) begin
          go      = 1'b1;
          go_kind = FK_DUMMY;
        end
      end
      ST_WAKE: begin
        if (wcnt >= WW'(WAKE_CYC - 1) && qcnt >= QW'(QUIET_CYC - 1)) begin
          go      = 1'b1;
          go_kind = FK_DISCARD;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      kind   <= FK_READ;
      cs_n_o <= 1'b1;
      run_o  <= 1'b0;
      fcnt   <= '0;
      qcnt   <= '0;
      wcnt   <= '0;
      pend   <= 1'b0;
    end else begin
      if (go) begin
        state  <= ST_FRAME;
        kind   <= go_kind;
        cs_n_o <= 1'b0;
        run_o  <= 1'b1;
        fcnt   <= '0;
        wcnt   <= '0;
      end else begin
        case (state)
          ST_FRAME: begin
            if (fall_now_i) fcnt <= fcnt + 1'b1;
            if (wcnt != WW'(WAKE_CYC)) wcnt <= wcnt + 1'b1;
            if (end_hit) begin
              cs_n_o <= 1'b1;
              run_o  <= 1'b0;
              qcnt   <= '0;
              state  <= (kind == FK_DUMMY) ? ST_WAKE : ST_QUIET;
            end
          end
          ST_QUIET: begin
            qcnt <= qcnt + 1'b1;
            if (qcnt == QW'(QUIET_CYC - 1))
              state <= (kind == FK_PWRDN) ? ST_SLEEP : ST_IDLE;
          end
          ST_WAKE: begin
            if (qcnt != QW'(QUIET_CYC)) qcnt <= qcnt + 1'b1;
            if (wcnt != WW'(WAKE_CYC))  wcnt <= wcnt + 1'b1;
          end
          default: ;
        endcase
      end
      if (state == ST_IDLE && go && go_kind == FK_READ) pend <= 1'b0;
      else if (start_i && hold_ok)                      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DATA_W      = 10,
  parameter int SHORT_FRAME = 0,
  parameter int CLK_DIV     = 3,
  parameter int QUIET_CYC   = 6,
  parameter int WAKE_CYC    = 100,
  parameter int PD_EDGE     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              pd_req_i,
  input  logic              wake_req_i,
  input  logic              sdo_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              ready_o
);
  logic run, fall_now, rise_now, shift, emit;

  adc_rd_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .sclk_o     (sclk_o),
    .fall_now_o (fall_now),
    .rise_now_o (rise_now)
  );

  adc_rd_seq #(
    .DATA_W      (DATA_W),
    .SHORT_FRAME (SHORT_FRAME),
    .QUIET_CYC   (QUIET_CYC),
    .WAKE_CYC    (WAKE_CYC),
    .PD_EDGE     (PD_EDGE)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .pd_req_i   (pd_req_i),
    .wake_req_i (wake_req_i),
    .fall_now_i (fall_now),
    .rise_now_i (rise_now),
    .run_o      (run),
    .cs_n_o     (cs_n_o),
    .shift_o    (shift),
    .emit_o     (emit),
    .ready_o    (ready_o)
  );

  adc_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .shift_i (shift),
    .sdo_i   (sdo_i),
    .emit_i  (emit),
    .valid_o (smp_valid_o),
    .data_o  (smp_data_o)
  );
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SHORT_FRAME = 0,
  parameter int QUIET_CYC   = 6,
  parameter int PD_EDGE     = 5
) (
  input logic clk,
  input logic rst,
  input logic cs_n_o,
  input logic sclk_o,
  input logic smp_valid_o,
  input logic ready_o
);
  localparam int READ_FALLS = (SHORT_FRAME != 0 && DATA_W <= 8) ? SHORT_FALLS : FULL_FALLS;
  localparam int HW = $clog2(QUIET_CYC + 1);

  logic [4:0]    fc;
  logic [HW-1:0] hc;
  logic          sclk_q;

  // falling edges seen while chip select is low; high-time counter between frames
  always_ff @(posedge clk) begin
    if (rst) begin
      fc     <= '0;
      hc     <= HW'(QUIET_CYC);
      sclk_q <= 1'b1;
    end else begin
      sclk_q <= sclk_o;
      if (cs_n_o) fc <= '0;
      else if (sclk_q && !sclk_o) fc <= fc + 1'b1;
      if (!cs_n_o) hc <= '0;
      else if (hc != HW'(QUIET_CYC)) hc <= hc + 1'b1;
    end
  end

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);

  p_frame_len_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> (fc == 5'(READ_FALLS) || fc == 5'(PD_EDGE) || fc == 5'(WAKE_FALLS)));

  p_valid_at_end_r2: assert property (@(posedge clk) disable iff (rst)
    smp_valid_o |-> ($rose(cs_n_o) && fc == 5'(READ_FALLS)));

  p_quiet_gap_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (hc >= HW'(QUIET_CYC)));

  p_ready_idle_r5: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (cs_n_o && !smp_valid_o));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .DATA_W      (DATA_W),
  .SHORT_FRAME (SHORT_FRAME),
  .QUIET_CYC   (QUIET_CYC),
  .PD_EDGE     (PD_EDGE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .smp_valid_o (smp_valid_o),
  .ready_o     (ready_o)
);

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_bfm #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] val,
  output logic              sdo
);
  int cyc, frames, falls, last_falls, vcnt, last_data;
  int low_min, low_max, gap_min, wake_gap, start_cyc, end_cyc, fall_cyc;
  bit hi_seen;
  logic prev_cs, prev_sclk;
  logic [15:0] word;

  assign word = {4'b0000, val, {(12 - DATA_W){1'b0}}};

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; frames = 0; falls = 0; last_falls = -1; vcnt = 0; last_data = -1;
      low_min = 1000; low_max = 0; gap_min = 1000; wake_gap = -1;
      start_cyc = 0; end_cyc = 0; fall_cyc = 0; hi_seen = 0;
      prev_cs = 1'b1; prev_sclk = 1'b1; sdo = 1'b0;
    end else begin
      cyc++;
      if (prev_cs && !cs_n) begin
        frames++;
        if (hi_seen && (cyc - end_cyc) < gap_min) gap_min = cyc - end_cyc;
        if (last_falls == 11) wake_gap = cyc - start_cyc;
        start_cyc = cyc;
        falls = 0;
        sdo = word[15];
      end else if (!cs_n && prev_sclk && !sclk) begin
        falls++;
        fall_cyc = cyc;
        sdo = (falls < 16) ? word[15 - falls] : 1'b0;
      end
      if (!cs_n && !prev_sclk && sclk) begin
        if (cyc - fall_cyc < low_min) low_min = cyc - fall_cyc;
        if (cyc - fall_cyc > low_max) low_max = cyc - fall_cyc;
      end
      if (!prev_cs && cs_n) begin
        last_falls = falls;
        end_cyc = cyc;
        hi_seen = 1;
      end
      if (valid) begin
        vcnt++;
        last_data = int'(data);
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end
endmodule

module adc_rd_ctrl_bench;
  localparam int CLK_DIV   = 3;
  localparam int QUIET_CYC = 6;
  localparam int WAKE_CYC  = 100;
  localparam int PD_EDGE   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, pd = 1'b0, wk = 1'b0;
  logic start8 = 1'b0;
  logic sdo, cs_n, sclk, vld, rdy;
  logic sdo8, cs_n8, sclk8, vld8, rdy8;
  logic [9:0] data, val10 = '0;
  logic [7:0] data8, val8 = '0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  adc_rd_ctrl #(.DATA_W(10), .SHORT_FRAME(0), .CLK_DIV(CLK_DIV), .QUIET_CYC(QUIET_CYC),
                .WAKE_CYC(WAKE_CYC), .PD_EDGE(PD_EDGE)) u_adc_rd_ctrl (
    .clk(clk), .rst(rst), .start_i(start), .pd_req_i(pd), .wake_req_i(wk), .sdo_i(sdo),
    .cs_n_o(cs_n), .sclk_o(sclk), .smp_valid_o(vld), .smp_data_o(data), .ready_o(rdy));

  adc_rd_ctrl #(.DATA_W(8), .SHORT_FRAME(1), .CLK_DIV(CLK_DIV), .QUIET_CYC(QUIET_CYC),
                .WAKE_CYC(WAKE_CYC), .PD_EDGE(PD_EDGE)) u_adc_rd_ctrl_s8 (
    .clk(clk), .rst(rst), .start_i(start8), .pd_req_i(1'b0), .wake_req_i(1'b0), .sdo_i(sdo8),
    .cs_n_o(cs_n8), .sclk_o(sclk8), .smp_valid_o(vld8), .smp_data_o(data8), .ready_o(rdy8));

  adc_rd_bfm #(.DATA_W(10)) u_bfm (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .valid(vld), .data(data), .val(val10), .sdo(sdo));
  adc_rd_bfm #(.DATA_W(8)) u_bfm8 (.clk(clk), .rst(rst), .cs_n(cs_n8), .sclk(sclk8),
    .valid(vld8), .data(data8), .val(val8), .sdo(sdo8));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rdy(input int lim);
    for (int i = 0; i < lim && !rdy; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit s, input bit p, input bit w);
    @(negedge clk);
    start = s; pd = p; wk = w;
    @(negedge clk);
    start = 0; pd = 0; wk = 0;
  endtask

  task automatic t_reset;
    chk(cs_n == 1'b1, "R1", "cs_n after reset", int'(cs_n), 1);
    chk(sclk == 1'b1, "R1", "sclk idle after reset", int'(sclk), 1);
    chk(vld == 1'b0, "R2", "valid after reset", int'(vld), 0);
    chk(rdy == 1'b1, "R5", "ready after reset", int'(rdy), 1);
  endtask

  task automatic t_read(input logic [9:0] v);
    int f0, c0;
    val10 = v;
    f0 = u_bfm.frames; c0 = u_bfm.vcnt;
    pulse(1, 0, 0);
    chk(rdy == 1'b0, "R5", "ready during frame", int'(rdy), 0);
    for (int i = 0; i < 400 && u_bfm.vcnt == c0; i++) @(negedge clk);
    chk(rdy == 1'b0, "R5", "ready in quiet period", int'(rdy), 0);
    chk(u_bfm.last_falls == 16, "R1", "read frame falling edges", u_bfm.last_falls, 16);
    chk(u_bfm.last_data == int'(v), "R2", "sample value", u_bfm.last_data, int'(v));
    wait_rdy(100);
    chk(u_bfm.frames - f0 == 1 && u_bfm.vcnt - c0 == 1, "R2", "one frame one sample",
        u_bfm.vcnt - c0, 1);
  endtask

  task automatic t_busy_start;
    int f0, c0;
    val10 = 10'h0F0;
    f0 = u_bfm.frames; c0 = u_bfm.vcnt;
    pulse(1, 0, 0);
    idle(20);
    pulse(1, 0, 0);
    wait_rdy(400);
    idle(200);
    chk(u_bfm.frames - f0 == 1, "R6", "frames after start while busy", u_bfm.frames - f0, 1);
    chk(u_bfm.vcnt - c0 == 1, "R6", "samples after start while busy", u_bfm.vcnt - c0, 1);
  endtask

  task automatic t_priority;
    int f0;
    f0 = u_bfm.frames;
    pulse(1, 1, 0);
    wait_rdy(400);
    chk(u_bfm.last_falls == 16, "R12", "frame kind on start+pd", u_bfm.last_falls, 16);
    idle(50);
    chk(rdy == 1'b1 && u_bfm.frames - f0 == 1, "R12", "still awake after start+pd", int'(rdy), 1);
  endtask

  task automatic t_ignored;
    int f0;
    f0 = u_bfm.frames;
    pulse(0, 0, 1);
    idle(50);
    chk(u_bfm.frames == f0 && rdy == 1'b1, "R13", "frames after wake while awake",
        u_bfm.frames - f0, 0);
    pulse(1, 0, 0);
    idle(10);
    pulse(0, 1, 0);
    wait_rdy(400);
    idle(50);
    chk(u_bfm.frames - f0 == 1 && rdy == 1'b1, "R13", "frames after pd during read",
        u_bfm.frames - f0, 1);
  endtask

  task automatic t_sleep_wake_held;
    int f0, c0;
    f0 = u_bfm.frames; c0 = u_bfm.vcnt;
    pulse(0, 1, 0);
    idle(100);
    chk(u_bfm.last_falls == PD_EDGE && PD_EDGE >= 3 && PD_EDGE <= 9, "R7",
        "power-down frame falling edges", u_bfm.last_falls, PD_EDGE);
    chk(u_bfm.vcnt == c0, "R7", "samples from power-down frame", u_bfm.vcnt - c0, 0);
    chk(rdy == 1'b0, "R7", "ready while asleep", int'(rdy), 0);
    val10 = 10'h1C7;
    pulse(1, 0, 0);
    idle(200);
    chk(u_bfm.frames - f0 == 1, "R10", "frames started while asleep", u_bfm.frames - f0, 1);
    pulse(0, 0, 1);
    idle(10);
    chk(rdy == 1'b0, "R5", "ready during wake sequence", int'(rdy), 0);
    wait_rdy(3000);
    chk(u_bfm.wake_gap >= WAKE_CYC, "R8", "cycles from dummy frame to next frame",
        u_bfm.wake_gap, WAKE_CYC);
    chk(u_bfm.frames - f0 == 4, "R10", "frames pd+dummy+discard+read", u_bfm.frames - f0, 4);
    chk(u_bfm.vcnt - c0 == 1, "R10", "samples from held start", u_bfm.vcnt - c0, 1);
    chk(u_bfm.last_data == 32'h1C7, "R10", "held read value", u_bfm.last_data, 32'h1C7);
  endtask

  task automatic t_sleep_wake_plain;
    int f0, c0;
    f0 = u_bfm.frames; c0 = u_bfm.vcnt;
    pulse(0, 1, 0);
    idle(100);
    pulse(0, 0, 1);
    wait_rdy(3000);
    chk(u_bfm.frames - f0 == 3, "R9", "frames pd+dummy+discard", u_bfm.frames - f0, 3);
    chk(u_bfm.vcnt == c0, "R9", "samples from discarded frame", u_bfm.vcnt - c0, 0);
    chk(u_bfm.last_falls == 16, "R9", "discard frame falling edges", u_bfm.last_falls, 16);
  endtask

  task automatic t_short;
    int c0;
    val8 = 8'hC3;
    c0 = u_bfm8.vcnt;
    @(negedge clk); start8 = 1;
    @(negedge clk); start8 = 0;
    for (int i = 0; i < 400 && u_bfm8.vcnt == c0; i++) @(negedge clk);
    chk(u_bfm8.last_falls == 12, "R11", "short frame falling edges", u_bfm8.last_falls, 12);
    chk(u_bfm8.last_data == 32'hC3, "R11", "short frame value", u_bfm8.last_data, 32'hC3);
    for (int i = 0; i < 100 && !rdy8; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(10'h2A5);
    t_read(10'h3FF);
    t_read(10'h000);
    t_read(10'h155);
    t_read(10'h200);
    t_busy_start();
    t_priority();
    t_ignored();
    t_sleep_wake_held();
    t_sleep_wake_plain();
    t_short();
    chk(u_bfm.low_min == CLK_DIV && u_bfm.low_max == CLK_DIV, "R3", "sclk low phase cycles",
        u_bfm.low_max, CLK_DIV);
    chk(u_bfm8.low_min == CLK_DIV && u_bfm8.low_max == CLK_DIV, "R3", "short sclk low phase",
        u_bfm8.low_max, CLK_DIV);
    chk(u_bfm.gap_min >= QUIET_CYC, "R4", "min chip-select high gap", u_bfm.gap_min, QUIET_CYC);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule